// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address for each beat of a synchronous burst read from a memory array. A one-cycle start strobe carries a starting word address and a 3-bit burst mode. From the next cycle on, the block presents an address on `addr_o`. It raises `rdy_o` whenever that address is being served. A word counts as transferred in any cycle where `rdy_o` is high; this is called a beat. After each beat the block steps to the next address.

There are three kinds of burst. A wrapping burst circles inside the aligned 8-, 16- or 32-word group that holds the start address. A fixed-length burst gives 8, 16 or 32 consecutive words and then reports completion. A continuous burst counts upward with no limit.

Fixed-length and continuous bursts can step across a 64-word internal boundary. When that happens, the new address is shown at once, but `rdy_o` stays low for a set number of latency cycles. The array can also hold off beats at any time by dropping its ready input. A fresh start strobe always takes effect, even while a burst is running.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `addr_o` is 0 and both `rdy_o` and `done_o` are low, until the first start strobe.
- R2: A start strobe makes `addr_o` equal to `start_addr_i` in the following cycle and clears `done_o`.
- R3: `rdy_o` is high only while a burst is running (not stalled, not finished) and `array_rdy_i` is high; a beat is a cycle with `rdy_o` high and no start strobe.
- R4: Modes 1, 2 and 3 are wrapping bursts of 8, 16 and 32 words: each beat adds one within the aligned group of that size that holds the start address, and the step after the group's top address returns to its base (start 39h in 8-word mode gives 39h..3Fh, then 38h, then 39h again). The burst continues until the next start.
- R5: A wrapping burst never inserts latency: with `array_rdy_i` held high, beats are back to back.
- R6: Modes 5, 6 and 7 are fixed bursts of 8, 16 and 32 words from the start address, each address one above the last, with no group limit. After the last beat, `done_o` is high and `rdy_o` low, and `addr_o` holds the last address until the next start.
- R7: Modes 0 and 4 are continuous: the address rises by one per beat without limit and wraps from all ones to zero.
- R8: In fixed and continuous bursts, a beat whose next address is a multiple of 64 (including the wrap to zero) shows that address at once, holds `rdy_o` low for exactly `STALL_CYC` cycles (default 2), and then resumes.
- R9: A start strobe during a running, stalled or finished burst abandons it: the new address and mode take effect in the next cycle, with no leftover latency.
- R10: While no beat occurs and no start strobe is given (including when `array_rdy_i` is low), `addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that begins a new burst |
| start_addr_i | input | ADDR_W | Starting word address, sampled with `start_i` |
| mode_i | input | 3 | Burst mode, sampled with `start_i` (0/4 continuous, 1-3 wrap 8/16/32, 5-7 fixed 8/16/32) |
| array_rdy_i | input | 1 | Array can serve the current address this cycle |
| addr_o | output | ADDR_W | Current word address |
| rdy_o | output | 1 | Current address is being served; a beat occurs this cycle |
| done_o | output | 1 | Fixed-length burst has delivered all its words |

## Verification
The assertions assume two things about the inputs. First, `start_i` is never asserted together with a beat the checker expects to step the address; this holds because a start strobe cancels the beat. Second, `mode_i` and `start_addr_i` are only meaningful in the cycle of the strobe.

The bench drives every input at the falling edge and pulses `start_i` for exactly one cycle. It holds `array_rdy_i` high during the walked vectors, so that any gap between beats can only come from boundary latency. It then lowers `array_rdy_i` only in a directed test that checks the address is held.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CONT  = 2'd0,
    KIND_WRAP  = 2'd1,
    KIND_FIXED = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STALL = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  // Burst mode decode: 1..3 wrap, 5..7 fixed, 0 and 4 continuous.
  function automatic kind_e mode_kind(input logic [2:0] m);
    case (m)
      3'd1, 3'd2, 3'd3: mode_kind = KIND_WRAP;
      3'd5, 3'd6, 3'd7: mode_kind = KIND_FIXED;
      default:          mode_kind = KIND_CONT;
    endcase
  endfunction

  // log2 of the burst length / group size carried by the low mode bits.
  function automatic logic [2:0] mode_len_log2(input logic [2:0] m);
    case (m[1:0])
      2'd1:    mode_len_log2 = 3'd3;
      2'd2:    mode_len_log2 = 3'd4;
      2'd3:    mode_len_log2 = 3'd5;
      default: mode_len_log2 = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BND_LOG2 = 6
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  kind_e             kind,
  input  logic [2:0]        len_log2,
  output logic [ADDR_W-1:0] next_addr,
  output logic              crosses
);

  function automatic logic [ADDR_W-1:0] group_mask(input logic [2:0] lg2);
    logic [ADDR_W-1:0] one;
    one = {{(ADDR_W-1){1'b0}}, 1'b1};
    group_mask = (one << lg2) - one;
  endfunction

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    inc  = cur_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
    mask = group_mask(len_log2);
    if (kind == KIND_WRAP) begin
      next_addr = (cur_addr & ~mask) | (inc & mask);
      crosses   = 1'b0;
    end else begin
      next_addr = inc;
      crosses   = (inc[BND_LOG2-1:0] == '0);
    end
  end

endmodule

// File: rtl/burst_beat_count.sv
module burst_beat_count
  import burst_seq_pkg::*;
#(
  parameter int MAX_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] len_log2,
  input  kind_e      kind,
  input  logic       beat,
  output logic       last
);

  localparam int CW = MAX_LOG2 + 1;

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= {{(CW-1){1'b0}}, 1'b1} << len_log2;
    end else if (beat && remain_q != '0) begin
      remain_q <= remain_q - {{(CW-1){1'b0}}, 1'b1};
    end
  end

  assign last = (kind == KIND_FIXED) && (remain_q == {{(CW-1){1'b0}}, 1'b1});

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int STALL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic beat,
  input  logic crossing,
  input  logic last,
  output logic running,
  output logic finished
);

  localparam int LW = (STALL_CYC < 2) ? 1 : $clog2(STALL_CYC + 1);
  localparam logic [LW-1:0] STALL_LOAD = LW'(STALL_CYC);
  localparam logic [LW-1:0] ONE        = LW'(1);

  state_e        state_q;
  logic [LW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
    end else if (start) begin
      state_q <= ST_RUN;
      wait_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (beat && last) begin
            state_q <= ST_DONE;
          end else if (beat && crossing) begin
            state_q <= ST_STALL;
            wait_q  <= STALL_LOAD;
          end
        end
        ST_STALL: begin
          if (wait_q <= ONE) begin
            state_q <= ST_RUN;
            wait_q  <= '0;
          end else begin
            wait_q <= wait_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign running  = (state_q == ST_RUN);
  assign finished = (state_q == ST_DONE);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BND_LOG2  = 6,
  parameter int STALL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        mode_i,
  input  logic              array_rdy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rdy_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] addr_q;
  kind_e             kind_q;
  logic [2:0]        lg2_q;

  logic [ADDR_W-1:0] next_addr;
  logic              crossing;
  logic              last_beat;
  logic              running;
  logic              finished;
  logic              beat;

  assign rdy_o  = running && array_rdy_i;
  assign beat   = rdy_o && !start_i;
  assign addr_o = addr_q;
  assign done_o = finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= KIND_CONT;
      lg2_q  <= '0;
    end else if (start_i) begin
      addr_q <= start_addr_i;
      kind_q <= mode_kind(mode_i);
      lg2_q  <= mode_len_log2(mode_i);
    end else if (beat && !last_beat) begin
      addr_q <= next_addr;
    end
  end

  burst_addr_step #(.ADDR_W(ADDR_W), .BND_LOG2(BND_LOG2)) u_step (
    .cur_addr (addr_q),
    .kind     (kind_q),
    .len_log2 (lg2_q),
    .next_addr(next_addr),
    .crosses  (crossing)
  );

  burst_beat_count #(.MAX_LOG2(5)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_i),
    .len_log2(mode_len_log2(mode_i)),
    .kind    (kind_q),
    .beat    (beat),
    .last    (last_beat)
  );

  burst_seq_ctrl #(.STALL_CYC(STALL_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .beat    (beat),
    .crossing(crossing),
    .last    (last_beat),
    .running (running),
    .finished(finished)
  );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              array_rdy_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rdy_o,
  input logic              done_o,
  input logic              beat,
  input logic              crossing,
  input logic              last_beat,
  input kind_e             kind_q,
  input logic [2:0]        lg2_q
);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (addr_o == $past(start_addr_i)) && !done_o); // R2

  AST_RDY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> array_rdy_i); // R3

  AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && kind_q == KIND_WRAP) |=> (((addr_o ^ $past(addr_o)) >> $past(lg2_q)) == '0)); // R4

  AST_WRAP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && kind_q == KIND_WRAP) |=> (rdy_o || !array_rdy_i)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rdy_o); // R6

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && kind_q != KIND_WRAP && !last_beat) |=> (addr_o == $past(addr_o) + 1'b1)); // R7

  AST_CROSS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && crossing && !last_beat) |=> !rdy_o); // R8

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !start_i) |=> $stable(addr_o)); // R10

endmodule

bind burst_addr_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_addr_i(start_addr_i),
  .array_rdy_i (array_rdy_i),
  .addr_o      (addr_o),
  .rdy_o       (rdy_o),
  .done_o      (done_o),
  .beat        (beat),
  .crossing    (crossing),
  .last_beat   (last_beat),
  .kind_q      (kind_q),
  .lg2_q       (lg2_q)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  localparam int AW  = 24;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [2:0]    mode_i = '0;
  logic          array_rdy_i = 1'b1;
  logic [AW-1:0] addr_o;
  logic          rdy_o;
  logic          done_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BND_LOG2(6), .STALL_CYC(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .mode_i(mode_i), .array_rdy_i(array_rdy_i),
    .addr_o(addr_o), .rdy_o(rdy_o), .done_o(done_o)
  );

  // start address, mode, beats to observe
  localparam logic [47:0] VEC [0:9] = '{
    {24'h000039, 8'd1, 16'd10},
    {24'h000039, 8'd2, 16'd18},
    {24'h000039, 8'd3, 16'd34},
    {24'h000020, 8'd3, 16'd33},
    {24'h00003A, 8'd5, 16'd8},
    {24'h000039, 8'd6, 16'd16},
    {24'h000010, 8'd7, 16'd32},
    {24'h00003E, 8'd0, 16'd6},
    {24'h00007E, 8'd4, 16'd4},
    {24'hFFFFFE, 8'd0, 16'd5}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_wrap(input int m);
    return (m >= 1 && m <= 3);
  endfunction

  function automatic int exp_addr(input int s, input int m, input int k);
    int sz;
    if (is_wrap(m)) begin
      sz = 4 << m;
      return (s / sz) * sz + ((s % sz) + k) % sz;
    end
    return (s + k) % (1 << AW);
  endfunction

  function automatic int exp_gap(input int s, input int m, input int k);
    if (k == 0 || is_wrap(m)) return 0;
    return (((s + k) % 64) == 0) ? LAT : 0;
  endfunction

  task automatic pulse_start(input int a, input int m);
    start_i      = 1'b1;
    start_addr_i = AW'(a);
    mode_i       = 3'(m);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Wait for rdy_o, then compare address and gap; leaves time at the next negedge.
  task automatic take_beat(input int s, input int m, input int k, input string req);
    int gap = 0;
    while (!rdy_o && gap < 40) begin
      @(negedge clk);
      gap++;
    end
    check(gap == exp_gap(s, m, k), {req, " gap"}, gap, exp_gap(s, m, k));
    check(addr_o == AW'(exp_addr(s, m, k)), req, addr_o, exp_addr(s, m, k));
    @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  initial begin
    // R1: reset state
    #1;
    check(addr_o == '0 && !rdy_o && !done_o, "R1 during reset", {addr_o, rdy_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(addr_o == '0, "R1 addr after reset", addr_o, 0);
    check(!rdy_o && !done_o, "R1 flags after reset", {rdy_o, done_o}, 0);

    // Vector walk: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < 10; v++) begin
      int s = int'(VEC[v][47:24]);
      int m = int'(VEC[v][23:16]);
      int n = int'(VEC[v][15:0]);
      pulse_start(s, m);
      check(addr_o == AW'(s) && !done_o, "R2 start load", addr_o, s);
      for (int k = 0; k < n; k++) begin
        if (is_wrap(m))      take_beat(s, m, k, "R4 R5 wrap");
        else if (m >= 5)     take_beat(s, m, k, "R6 R8 fixed");
        else                 take_beat(s, m, k, "R7 R8 continuous");
      end
      if (m >= 5) begin
        check(done_o && !rdy_o, "R6 done after count", {done_o, rdy_o}, 2);
        repeat (4) @(negedge clk);
        check(done_o && !rdy_o, "R6 done holds", {done_o, rdy_o}, 2);
        check(addr_o == AW'(exp_addr(s, m, n - 1)), "R6 last addr holds", addr_o, exp_addr(s, m, n - 1));
      end
    end

    // R3 R10: array not ready holds address and keeps rdy_o low
    array_rdy_i = 1'b0;
    pulse_start(24'h100, 0);
    for (int i = 0; i < 3; i++) begin
      check(!rdy_o, "R3 rdy low while array busy", rdy_o, 0);
      check(addr_o == 24'h100, "R10 addr held", addr_o, 24'h100);
      @(negedge clk);
    end
    array_rdy_i = 1'b1;
    #0;
    check(rdy_o && addr_o == 24'h100, "R3 rdy follows array", addr_o, 24'h100);
    @(negedge clk);
    check(addr_o == 24'h101, "R10 advance after beat", addr_o, 24'h101);

    // R9: abort fixed burst mid-way into a wrap burst
    pulse_start(24'h39, 7);
    for (int k = 0; k < 3; k++) take_beat(24'h39, 7, k, "R9 pre-abort");
    pulse_start(24'h205, 1);
    check(addr_o == 24'h205 && rdy_o, "R9 abort reload", addr_o, 24'h205);
    for (int k = 0; k < 9; k++) take_beat(24'h205, 1, k, "R9 after abort");

    // R9: abort during boundary stall, no leftover latency
    pulse_start(24'h3F, 0);
    take_beat(24'h3F, 0, 0, "R9 before stall");
    check(!rdy_o && addr_o == 24'h40, "R8 stall shows new addr", addr_o, 24'h40);
    pulse_start(24'h80, 5);
    check(rdy_o && addr_o == 24'h80, "R9 abort stall", addr_o, 24'h80);

    // R2: restart after done clears done_o
    for (int k = 0; k < 8; k++) take_beat(24'h80, 5, k, "R6 second fixed");
    check(done_o, "R6 done set", done_o, 1);
    pulse_start(24'h10, 2);
    check(!done_o && addr_o == 24'h10, "R2 restart clears done", {done_o, addr_o}, 24'h10);

    summary();
  end

endmodule